// File: doc/BRIEF.md
# Reset and Oscillator Start-up Sequencer

This block decides when a small microcontroller core may run. It watches five conditions: an asynchronous power-on indication, an external active-low reset pin, a one-cycle watchdog time-out pulse, a HALT request from the core and a wake-up event. From these it drives a reset that puts the core's units into their initial state. It also drives a run enable that stalls the core and an enable for the system oscillator. While the oscillator may still be settling, a start-up timer holds the core back for a fixed number of clock cycles. Only some causes apply this delay. Power-up applies it, and so does every wake-up from HALT. An external pin reset does not apply it.

The block also keeps two cause flags. The time-out flag (TO) shows that the watchdog expired. The power-down flag (PD) shows that HALT was entered. Software reads the pair to tell a watchdog reset in normal operation (TO=1, PD unchanged) apart from a watchdog wake-up out of HALT (TO=1, PD=1). An event that does not concern a flag leaves that flag unchanged.

The sequencer is a six-state machine:
- PORDLY: reset held while the power-up delay runs.
- PINRST: reset held while the synchronised pin is asserted.
- WDTRST: a one-cycle reset after a watchdog time-out during normal operation.
- RUN: the core executes.
- HALT: the core is stalled and the oscillator is off.
- WAKEDLY: the core is stalled while the wake-up delay runs.

The transitions are:
- power-on: any state to PORDLY, asynchronously.
- PORDLY to RUN when the delay ends, or to PINRST if the pin is asserted at that moment.
- pin assert: RUN, WDTRST, HALT or WAKEDLY to PINRST.
- PINRST to RUN when the pin is released.
- RUN to WDTRST on a watchdog pulse.
- WDTRST to RUN.
- RUN to HALT on a HALT request.
- HALT to WAKEDLY on a wake event or a watchdog pulse.
- WAKEDLY to WAKEDLY on a further event, which reloads the timer.
- WAKEDLY to RUN when the delay ends.

Top module: `wake_reset_sequencer`

## Requirements
- R1: While por_i is high, core_rst_o=1, core_run_o=0, osc_en_o=1, to_flag_o=0 and pd_flag_o=0. After por_i falls, core_rst_o stays 1 and core_run_o stays 0 for exactly DLY_CYC cycles (default 1024), and then core_run_o=1 and core_rst_o=0. Neither flag ever falls except through por_i.
- R2: ext_rst_n_i passes through a two-flop synchroniser. core_rst_o rises on the third clock edge after the pin goes low and stays high while the pin is low. core_rst_o falls and core_run_o rises on the third edge after release, with no start-up delay. Both flags are unchanged.
- R3: A wdt_to_i pulse in RUN makes core_rst_o=1 for exactly one cycle, starting on the next edge. On that edge to_flag_o becomes 1 and pd_flag_o is unchanged. RUN follows.
- R4: halt_req_i in RUN gives core_run_o=0 and osc_en_o=0 on the next edge, with core_rst_o=0. pd_flag_o becomes 1 and to_flag_o is unchanged.
- R5: A wake_i pulse in HALT raises osc_en_o on the next edge. core_run_o then stays 0 for exactly DLY_CYC cycles, counted from that edge, and rises after them. core_rst_o stays 0 and the flags are unchanged.
- R6: A wdt_to_i pulse in HALT wakes the core as in R5, with to_flag_o=1 and pd_flag_o=1.
- R7: A wake_i or wdt_to_i pulse during the wake-up delay reloads the timer. core_run_o rises DLY_CYC cycles after the last such event.
- R8: With no wake_i, no wdt_to_i and no pin event, HALT persists with core_run_o=0 and osc_en_o=0. halt_req_i has no effect outside RUN.
- R9: Asserting the pin during HALT or during the wake-up delay resets the core as in R2, with no delay and with pd_flag_o kept.
- R10: A pin pulse during the power-up delay neither shortens nor lengthens it. core_run_o still rises DLY_CYC cycles after por_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on indication, active high, asynchronous |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_to_i | input | 1 | Watchdog time-out pulse, one cycle |
| halt_req_i | input | 1 | HALT request from the core |
| wake_i | input | 1 | Wake-up event |
| core_rst_o | output | 1 | 1 = hold the core in its reset state: PC=000h, interrupts disabled, prescaler and watchdog cleared, timers off, ports set to input, SP at the top of the stack. The watchdog counts once this is released. |
| core_run_o | output | 1 | 1 = the core may execute |
| osc_en_o | output | 1 | 1 = the system oscillator is enabled |
| to_flag_o | output | 1 | Watchdog time-out flag |
| pd_flag_o | output | 1 | Power-down flag |

## Verification
Every output is decoded from registered state. A watchdog pulse, a HALT request or a wake event is therefore visible one edge after the cycle in which it is presented. A pin change takes three edges: two in the synchroniser and one in the state register. Each delay takes exactly DLY_CYC cycles, counted from the edge that starts it. For a power-up delay, that is the release of por_i. The bench drives inputs on the falling clock edge and samples on the falling edge after the expected edge. It measures each delay by counting falling-edge samples in which core_run_o is low, and compares that count with DLY_CYC. For the pin, it checks that core_rst_o has not yet changed one sample before the third edge.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
    typedef enum logic [2:0] {
        S_PORDLY  = 3'd0,
        S_PINRST  = 3'd1,
        S_WDTRST  = 3'd2,
        S_RUN     = 3'd3,
        S_HALT    = 3'd4,
        S_WAKEDLY = 3'd5
    } seq_state_t;
endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_i,
    input  logic pin_n_i,
    output logic pin_rst_o
);
    logic [STAGES-1:0] sync_q;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], ~pin_n_i};
        end
    end

    assign pin_rst_o = sync_q[STAGES-1];
endmodule

// File: rtl/startup_timer.sv
module startup_timer #(
    parameter int DLY_CYC = 1024
) (
    input  logic clk,
    input  logic por_i,
    input  logic load_i,
    input  logic en_i,
    output logic done_o
);
    localparam int CW = (DLY_CYC > 2) ? $clog2(DLY_CYC) : 1;
    localparam logic [CW-1:0] LOAD_V = CW'(DLY_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            cnt_q <= LOAD_V;
        end else if (load_i) begin
            cnt_q <= LOAD_V;
        end else if (en_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

    // R7
    reload_restart_chk: assert property (@(posedge clk) disable iff (por_i)
        load_i |=> !done_o);
endmodule

// File: rtl/status_flags.sv
module status_flags (
    input  logic clk,
    input  logic por_i,
    input  logic set_to_i,
    input  logic set_pd_i,
    output logic to_o,
    output logic pd_o
);
    logic to_q;
    logic pd_q;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            to_q <= 1'b0;
            pd_q <= 1'b0;
        end else begin
            if (set_to_i) to_q <= 1'b1;
            if (set_pd_i) pd_q <= 1'b1;
        end
    end

    assign to_o = to_q;
    assign pd_o = pd_q;

    // R1
    flags_sticky_chk: assert property (@(posedge clk) disable iff (por_i)
        !$fell(to_q) && !$fell(pd_q));
endmodule

// File: rtl/wake_reset_sequencer.sv
module wake_reset_sequencer
    import wrs_pkg::*;
#(
    parameter int DLY_CYC = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_i,
    input  logic ext_rst_n_i,
    input  logic wdt_to_i,
    input  logic halt_req_i,
    input  logic wake_i,
    output logic core_rst_o,
    output logic core_run_o,
    output logic osc_en_o,
    output logic to_flag_o,
    output logic pd_flag_o
);
    seq_state_t state_q;
    seq_state_t state_d;
    logic       pin_rst;
    logic       tmr_done;
    logic       tmr_load;
    logic       tmr_en;
    logic       set_to;
    logic       set_pd;
    logic       wake_evt;

    rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .por_i    (por_i),
        .pin_n_i  (ext_rst_n_i),
        .pin_rst_o(pin_rst)
    );

    startup_timer #(.DLY_CYC(DLY_CYC)) u_timer (
        .clk   (clk),
        .por_i (por_i),
        .load_i(tmr_load),
        .en_i  (tmr_en),
        .done_o(tmr_done)
    );

    status_flags u_flags (
        .clk     (clk),
        .por_i   (por_i),
        .set_to_i(set_to),
        .set_pd_i(set_pd),
        .to_o    (to_flag_o),
        .pd_o    (pd_flag_o)
    );

    assign wake_evt = wake_i | wdt_to_i;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            state_q <= S_PORDLY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_PORDLY: begin
                if (tmr_done) state_d = pin_rst ? S_PINRST : S_RUN;
            end
            S_PINRST: begin
                if (!pin_rst) state_d = S_RUN;
            end
            S_WDTRST: begin
                state_d = pin_rst ? S_PINRST : S_RUN;
            end
            S_RUN: begin
                if (pin_rst)         state_d = S_PINRST;
                else if (wdt_to_i)   state_d = S_WDTRST;
                else if (halt_req_i) state_d = S_HALT;
            end
            S_HALT: begin
                if (pin_rst)       state_d = S_PINRST;
                else if (wake_evt) state_d = S_WAKEDLY;
            end
            S_WAKEDLY: begin
                if (pin_rst)                    state_d = S_PINRST;
                else if (!wake_evt && tmr_done) state_d = S_RUN;
            end
            default: state_d = S_PORDLY;
        endcase
    end

    always_comb begin
        tmr_load = 1'b0;
        tmr_en   = 1'b0;
        set_to   = 1'b0;
        set_pd   = 1'b0;
        unique case (state_q)
            S_PORDLY: tmr_en = 1'b1;
            S_RUN: begin
                set_to = !pin_rst && wdt_to_i;
                set_pd = !pin_rst && !wdt_to_i && halt_req_i;
            end
            S_HALT, S_WAKEDLY: begin
                tmr_en   = (state_q == S_WAKEDLY);
                tmr_load = !pin_rst && wake_evt;
                set_to   = !pin_rst && wdt_to_i;
            end
            default: ;
        endcase
    end

    always_comb begin
        core_rst_o = 1'b0;
        core_run_o = 1'b0;
        osc_en_o   = 1'b1;
        unique case (state_q)
            S_PORDLY, S_PINRST, S_WDTRST: core_rst_o = 1'b1;
            S_RUN:                        core_run_o = 1'b1;
            S_HALT:                       osc_en_o   = 1'b0;
            default: ;
        endcase
    end

    // R3
    wdt_run_reset_chk: assert property (@(posedge clk) disable iff (por_i)
        (core_run_o && wdt_to_i && !pin_rst) |=> (core_rst_o && to_flag_o));

    // R4
    pd_on_halt_chk: assert property (@(posedge clk) disable iff (por_i)
        $rose(pd_flag_o) |-> (!osc_en_o && !core_run_o && !core_rst_o));

    // R5
    wake_delay_done_chk: assert property (@(posedge clk) disable iff (por_i)
        ($rose(core_run_o) && $past(state_q) == S_WAKEDLY) |-> $past(tmr_done));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (por_i)
        (!osc_en_o && !pin_rst && !wake_evt) |=> (!osc_en_o && !core_run_o));
endmodule

// File: tb/wake_reset_sequencer_tb.sv
module wake_reset_sequencer_tb;
    localparam int N = 1024;

    typedef struct packed {
        logic [1:0] op;   // 0 none, 1 watchdog, 2 halt, 3 wake
        logic       rst;
        logic       run;
        logic       osc;
        logic       to;
        logic       pd;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 watchdog in RUN
        '{2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 back to RUN
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd4},  // R4 halt entry
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 halt_req in HALT
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 stays halted
        '{2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd5}   // R5 wake starts delay
    };

    logic clk = 1'b0;
    logic por = 1'b1;
    logic rst_n = 1'b1;
    logic wdt = 1'b0;
    logic halt = 1'b0;
    logic wake = 1'b0;
    logic core_rst, core_run, osc_en, to_f, pd_f;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wake_reset_sequencer #(.DLY_CYC(N)) u_dut (
        .clk        (clk),
        .por_i      (por),
        .ext_rst_n_i(rst_n),
        .wdt_to_i   (wdt),
        .halt_req_i (halt),
        .wake_i     (wake),
        .core_rst_o (core_rst),
        .core_run_o (core_run),
        .osc_en_o   (osc_en),
        .to_flag_o  (to_f),
        .pd_flag_o  (pd_f)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_out(input string tag, input logic [4:0] exp);
        check(tag, int'({core_rst, core_run, osc_en, to_f, pd_f}), int'(exp));
    endtask

    task automatic measure(output int n);
        n = 0;
        while (!core_run && n < 3 * N) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input logic [1:0] op);
        wdt  = (op == 2'd1);
        halt = (op == 2'd2);
        wake = (op == 2'd3);
        @(negedge clk);
        wdt  = 1'b0;
        halt = 1'b0;
        wake = 1'b0;
    endtask

    task automatic power_up(input string tag);
        int n;
        por = 1'b1;
        @(negedge clk);
        check_out({tag, " reset state"}, 5'b10100);
        por = 1'b0;
        measure(n);
        check({tag, " power-up delay"}, n, N);
        check_out({tag, " running"}, 5'b01100);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        @(negedge clk);
        @(negedge clk);
        power_up("R1");

        for (int i = 0; i < NV; i++) begin
            pulse(VEC[i].op);
            check_out($sformatf("R%0d vector %0d", VEC[i].req, i),
                      {VEC[i].rst, VEC[i].run, VEC[i].osc, VEC[i].to, VEC[i].pd});
        end
        measure(n);
        check("R5 wake delay", n, N);
        check_out("R5 after wake", 5'b01111);

        // R6: fresh power-up, then watchdog wake from HALT
        power_up("R1 second");
        pulse(2'd2);
        check_out("R4 to unchanged", 5'b00001);
        pulse(2'd1);
        check_out("R6 wdt wake", 5'b00111);
        measure(n);
        check("R6 wdt wake delay", n, N);

        // R7: reload on second event
        pulse(2'd2);
        pulse(2'd3);
        for (int i = 0; i < 100; i++) begin
            if (core_run) n = -1;
            @(negedge clk);
        end
        check("R7 stalled before reload", n, N);
        pulse(2'd3);
        measure(n);
        check("R7 reloaded delay", n, N);

        // R2: pin reset in RUN
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R2 latency not yet", int'(core_rst), 0);
        @(negedge clk);
        check_out("R2 pin reset", 5'b10111);
        repeat (10) @(negedge clk);
        check("R2 held", int'(core_rst), 1);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R2 release not yet", int'(core_rst), 1);
        @(negedge clk);
        check_out("R2 no delay", 5'b01111);

        // R9: pin during wake delay
        pulse(2'd2);
        pulse(2'd3);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_out("R9 pin in delay", 5'b10111);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_out("R9 run, pd kept", 5'b01111);

        // R10: pin pulse during power-up delay
        por = 1'b1;
        @(negedge clk);
        por = 1'b0;
        n = 0;
        while (!core_run && n < 3 * N) begin
            if (n == 100) rst_n = 1'b0;
            if (n == 105) rst_n = 1'b1;
            n++;
            @(negedge clk);
        end
        check("R10 delay unchanged", n, N);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule